// File: doc/BRIEF.md
# Serial Configuration ROM Loader

After a start pulse, this block reads every word of a small serial configuration ROM through a three-wire interface. The interface has a select line, a shift clock and a serial line in each direction. The ROM holds 64 words of 16 bits. The block reads the words at addresses 0 to 63, one after another, and performs no other operation. It keeps a wrapping 16-bit sum of all the words. It also takes the 48-bit station address from the first three words. When the last word has been added, the block raises `done`. From that point the address and the sum are stable for the system logic that reads them.

Each word access is one frame. The select line rises and the block shifts out a read command, which is a start marker, an opcode and the word address. The block then clocks in sixteen data bits. After that, all three output lines return low.

The shift clock is derived from the system clock. Each half period lasts `sclkHalf` system clocks. The integrator chooses this value so that each half period is at least 1 µs. For example, a 50 MHz system clock needs a value of 50.

Top module: `cfg_rom_loader`

## Requirements
- R1: While reset is asserted and just after it is released, `eeCs`, `eeSclk`, `eeDout` and `done` are low, and `macAddr` and `wordSum` are zero.
- R2: `eeCs` rises one half period before the first command bit. It stays high until the last data bit has been sampled. `eeSclk` is never high while `eeCs` is low. When `eeCs` falls, `eeSclk` and `eeDout` are already low.
- R3: Each frame shifts out 11 command bits, most significant first: 0, 0, 1, 1, 0, and then the 6-bit word address. `eeDout` is set while `eeSclk` is low and does not change while `eeSclk` is high.
- R4: After the command, each frame clocks in exactly 16 data bits, most significant first. Each bit is sampled at the last system clock of an `eeSclk` high half period, so every frame has exactly 27 rising edges of `eeSclk`.
- R5: One load performs exactly 64 frames, with addresses 0, 1, …, 63 in order. `done` rises only after the frame for address 63.
- R6: When `done` is high, `wordSum` equals the sum of all 64 words modulo 2^16.
- R7: When `done` is high, `macAddr[8*i+7:8*i]` holds byte i for i from 0 to 5. Byte i comes from word i/2: its low 8 bits for even i and its high 8 bits for odd i. So `macAddr = {word2, word1, word0}`.
- R8: Every high half period of `eeSclk` lasts max(`sclkHalf`,1) system clocks. The value used is the one present at the start pulse, and later changes have no effect until the next start.
- R9: A start pulse while a load is running is ignored. `done` stays high until the next start pulse is accepted. It is low in the cycle after that pulse, and a full new load follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| sclkHalf | input | 8 | Shift-clock half period in system clocks (0 acts as 1) |
| done | output | 1 | High once all words are read, until the next start |
| macAddr | output | 48 | Station address, byte 0 in bits 7:0 |
| wordSum | output | 16 | Wrapping sum of all words |
| eeCs | output | 1 | ROM select |
| eeSclk | output | 1 | ROM shift clock |
| eeDout | output | 1 | Serial command bits to the ROM |
| eeDin | input | 1 | Serial data bits from the ROM |

## Verification
Some internal faults appear on the ROM pins within the same frame. A wrong command-bit index or a wrong address counter changes the 11-bit command pattern, and the ROM model flags it when the 11th rising edge arrives. A wrong half-period count or a lost latch of the divider value changes the length of the very next `eeSclk` high phase.

Other faults only appear at the end of a load, about 3.6 k half periods later. A sampling-edge error or a wrong shift direction in the data register corrupts the words themselves, so it shows up in `wordSum` and `macAddr` once `done` rises. A sequencer that restarts on a mid-load start changes the frame count and the word order.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  // Width of the bit-position counter shared by command and data phases.
  localparam int IDX_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_DAT_LO,
    ST_DAT_HI,
    ST_END,
    ST_DONE
  } seqState_t;

  // Strobes from sequencer to datapath.
  typedef struct packed {
    logic             clear;    // start of a new load
    logic             shiftIn;  // sample eeDin into the word register
    logic             commit;   // word complete: accumulate, store, advance
    logic [IDX_W-1:0] bitIdx;   // current command bit position
  } dpStrobe_t;

endpackage

// File: rtl/cfg_rom_dpath.sv
module cfg_rom_dpath
  import cfg_rom_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 16,
  parameter int MAC_WORDS = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic                        eeDin,
  output logic                        cmdBit,
  output logic                        allRead,
  output logic [MAC_WORDS*WORD_W-1:0] macOut,
  output logic [WORD_W-1:0]           sumOut
);

  localparam int CMD_W   = ADDR_W + 5;
  localparam int N_WORDS = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_WORDS - 1);

  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] wordSh;
  logic [WORD_W-1:0] nextWord;
  logic [CMD_W-1:0]  cmdWord;
  logic [CMD_W-1:0]  cmdShifted;

  // Leading zeros, start marker, read opcode, then the word address.
  assign cmdWord    = {5'b00110, addr};
  assign cmdShifted = cmdWord >> strobe.bitIdx;
  assign cmdBit     = cmdShifted[0];

  // Word as it stands after the current sample.
  assign nextWord = {wordSh[WORD_W-2:0], eeDin};

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      addr    <= '0;
      wordSh  <= '0;
      sumOut  <= '0;
      macOut  <= '0;
      allRead <= 1'b0;
    end else begin
      if (strobe.shiftIn) wordSh <= nextWord;
      if (strobe.commit) begin
        sumOut <= sumOut + nextWord;
        addr   <= addr + 1'b1;
        if (addr == LAST_ADDR) allRead <= 1'b1;
        for (int i = 0; i < MAC_WORDS; i++) begin
          if (addr == ADDR_W'(i)) macOut[i*WORD_W +: WORD_W] <= nextWord;
        end
      end
    end
  end

  AST_SUM_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (allRead && !strobe.clear) |=> $stable(sumOut)); // R6

endmodule

// File: rtl/cfg_rom_ctrl.sv
module cfg_rom_ctrl
  import cfg_rom_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] sclkHalf,
  input  logic             cmdBit,
  input  logic             allRead,
  output dpStrobe_t        strobe,
  output logic             eeCs,
  output logic             eeSclk,
  output logic             eeDout,
  output logic             done
);

  localparam int CMD_W = ADDR_W + 5;
  localparam logic [IDX_W-1:0] CMD_TOP  = IDX_W'(CMD_W - 1);
  localparam logic [IDX_W-1:0] DATA_TOP = IDX_W'(WORD_W - 1);

  seqState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLat;
  logic [IDX_W-1:0] bitCnt;
  logic             idle;
  logic             accept;
  logic             tick;
  logic             lastBit;

  assign idle    = (state == ST_IDLE) || (state == ST_DONE);
  assign accept  = start && idle;
  assign tick    = !idle && (divCnt == halfLat - 1'b1);
  assign lastBit = (bitCnt == '0);

  always_comb begin
    strobe.clear   = accept;
    strobe.shiftIn = (state == ST_DAT_HI) && tick;
    strobe.commit  = (state == ST_DAT_HI) && tick && lastBit;
    strobe.bitIdx  = bitCnt;
  end

  // Pin levels decoded straight from the state register.
  assign eeCs   = !idle && (state != ST_END);
  assign eeSclk = (state == ST_CMD_HI) || (state == ST_DAT_HI);
  assign eeDout = ((state == ST_CMD_LO) || (state == ST_CMD_HI)) && cmdBit;
  assign done   = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      halfLat <= DIV_W'(1);
      bitCnt  <= '0;
    end else if (accept) begin
      state   <= ST_SEL;
      divCnt  <= '0;
      halfLat <= (sclkHalf == '0) ? DIV_W'(1) : sclkHalf;
    end else if (tick) begin
      divCnt <= '0;
      unique case (state)
        ST_SEL: begin
          state  <= ST_CMD_LO;
          bitCnt <= CMD_TOP;
        end
        ST_CMD_LO: state <= ST_CMD_HI;
        ST_CMD_HI: begin
          if (lastBit) begin
            state  <= ST_DAT_LO;
            bitCnt <= DATA_TOP;
          end else begin
            state  <= ST_CMD_LO;
            bitCnt <= bitCnt - 1'b1;
          end
        end
        ST_DAT_LO: state <= ST_DAT_HI;
        ST_DAT_HI: begin
          if (lastBit) begin
            state <= ST_END;
          end else begin
            state  <= ST_DAT_LO;
            bitCnt <= bitCnt - 1'b1;
          end
        end
        ST_END:  state <= allRead ? ST_DONE : ST_SEL;
        default: state <= ST_IDLE;
      endcase
    end else if (!idle) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    eeSclk |-> eeCs); // R2

  AST_CS_DROP_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeCs) |-> (!eeSclk && !eeDout)); // R2

  AST_DOUT_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (eeSclk && $past(eeSclk)) |-> $stable(eeDout)); // R3

  AST_DONE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> allRead); // R5

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R9

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && start && state != ST_END) |=> (state != ST_SEL || $past(state) == ST_SEL)); // R9

endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
  import cfg_rom_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int WORD_W    = 16,
  parameter int MAC_WORDS = 3,
  parameter int DIV_W     = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [DIV_W-1:0]            sclkHalf,
  output logic                        done,
  output logic [MAC_WORDS*WORD_W-1:0] macAddr,
  output logic [WORD_W-1:0]           wordSum,
  output logic                        eeCs,
  output logic                        eeSclk,
  output logic                        eeDout,
  input  logic                        eeDin
);

  dpStrobe_t strobe;
  logic      cmdBit;
  logic      allRead;

  cfg_rom_ctrl #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W),
    .DIV_W (DIV_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .sclkHalf(sclkHalf),
    .cmdBit  (cmdBit),
    .allRead (allRead),
    .strobe  (strobe),
    .eeCs    (eeCs),
    .eeSclk  (eeSclk),
    .eeDout  (eeDout),
    .done    (done)
  );

  cfg_rom_dpath #(
    .ADDR_W   (ADDR_W),
    .WORD_W   (WORD_W),
    .MAC_WORDS(MAC_WORDS)
  ) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .eeDin  (eeDin),
    .cmdBit (cmdBit),
    .allRead(allRead),
    .macOut (macAddr),
    .sumOut (wordSum)
  );

endmodule

// File: tb/cfg_rom_loader_tb.sv
module cfg_rom_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_WORDS    = 64;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  sclkHalf = 8'd1;
  logic        done;
  logic [47:0] macAddr;
  logic [15:0] wordSum;
  logic        eeCs, eeSclk, eeDout;
  logic        eeDin = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  logic [15:0] seed = 16'h0000;
  int expHalf = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_rom_loader dut_i (
    .clk(clk), .rstN(rstN), .start(start), .sclkHalf(sclkHalf),
    .done(done), .macAddr(macAddr), .wordSum(wordSum),
    .eeCs(eeCs), .eeSclk(eeSclk), .eeDout(eeDout), .eeDin(eeDin)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wordOf(input int a, input logic [15:0] s);
    return 16'((a * 32'h2F1B) ^ (a << 9)) ^ s;
  endfunction

  // Behavioural ROM: captures command on rising shift clock, then returns data.
  int modelBits = 0;
  int frameCnt = 0;
  logic [10:0] cmdSh = '0;
  logic [15:0] curWord = '0;

  always @(posedge eeSclk or negedge eeCs) begin
    if (!eeCs) begin
      if (modelBits != 0) begin
        check(modelBits == 27, "R4 rising edges per frame", modelBits, 27);
        frameCnt++;
      end
      modelBits = 0;
      eeDin = 1'b0;
    end else begin
      if (modelBits < 11) begin
        cmdSh = {cmdSh[9:0], eeDout};
        if (modelBits == 10) begin
          check(cmdSh == {5'b00110, 6'(frameCnt % N_WORDS)}, "R3 command bits",
                cmdSh, {5'b00110, 6'(frameCnt % N_WORDS)});
          curWord = wordOf(frameCnt % N_WORDS, seed);
        end
      end else if (modelBits < 27) begin
        eeDin = curWord[15 - (modelBits - 11)];
      end
      modelBits++;
    end
  end

  // Pin-level monitors, sampled on the falling edge.
  int hiRun = 0;
  logic prevSclk = 1'b0;
  logic prevDout = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (eeSclk) begin
        hiRun++;
        if (!eeCs) check(1'b0, "R2 sclk without cs", 1, 0);
        if (prevSclk && eeDout != prevDout) check(1'b0, "R3 dout moved while sclk high", eeDout, prevDout);
      end else if (hiRun > 0) begin
        check(hiRun == expHalf, "R8 sclk high half period", hiRun, expHalf);
        hiRun = 0;
      end
    end
    prevSclk = eeSclk;
    prevDout = eeDout;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic runLoad(input int h, input logic [15:0] s, input bit midStart, input int lateHalf);
    int base;
    logic [15:0] expSum;
    logic [47:0] expMac;
    seed = s;
    expHalf = (h == 0) ? 1 : h;
    sclkHalf = 8'(h);
    base = frameCnt;
    pulseStart();
    check(done == 1'b0, "R9 done drops after start", done, 0);
    if (lateHalf >= 0) sclkHalf = 8'(lateHalf);  // R8 latched value
    if (midStart) begin
      repeat (500) @(negedge clk);
      pulseStart();  // R9 ignored while busy
    end
    while (!done) @(negedge clk);
    expSum = '0;
    for (int a = 0; a < N_WORDS; a++) expSum = expSum + wordOf(a, s);
    expMac = {wordOf(2, s), wordOf(1, s), wordOf(0, s)};
    check(frameCnt - base == N_WORDS, "R5 frames per load", frameCnt - base, N_WORDS);
    check(wordSum == expSum, "R6 word sum", wordSum, expSum);
    check(macAddr == expMac, "R7 station address", macAddr, expMac);
    check(macAddr[7:0] == wordOf(0, s)[7:0] && macAddr[15:8] == wordOf(0, s)[15:8],
          "R7 byte order", macAddr[15:0], wordOf(0, s));
    check(!eeCs && !eeSclk && !eeDout, "R2 lines idle after load", {eeCs, eeSclk, eeDout}, 0);
    repeat (25) @(negedge clk);
    check(done == 1'b1, "R9 done held", done, 1);
    check(wordSum == expSum, "R6 sum stable after done", wordSum, expSum);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!eeCs && !eeSclk && !eeDout && !done, "R1 pins in reset", {eeCs, eeSclk, eeDout, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!eeCs && !eeSclk && !eeDout && !done, "R1 pins after reset", {eeCs, eeSclk, eeDout, done}, 0);
    check(macAddr == '0 && wordSum == '0, "R1 outputs zero", {macAddr, wordSum}, 0);
    runLoad(0, 16'h0000, 1'b0, -1);
    runLoad(1, 16'hFFFF, 1'b0, -1);
    runLoad(2, 16'hA55A, 1'b0, 7);
    runLoad(3, 16'h1234, 1'b1, -1);
    runLoad(1, 16'h8001, 1'b1, 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule